// File: doc/BRIEF.md
# Supply Black-out Reset Sequencer

This block watches a single comparator flag that goes high whenever the regulated supply sits below the selected trigger threshold. It removes short dips and asserts an internal reset as soon as a dip is confirmed. In the same cycle it pulses a strobe that tells the non-volatile memory controller to abandon any write in flight and mark its result invalid. If the supply stays low for a fixed number of cycles while the chip is in normal operation, the reset escalates to a latched power-off request. Only a charger-present indication clears that request.

A set/reset latch drives the threshold select. Power-on reset, and leaving power-off, pick the start-up level (`sel_normal` = 0). A start-up-done strobe picks the normal level (`sel_normal` = 1). While the start-up level is selected, a confirmed black-out only resets and never escalates.

The controller has five states. STARTUP is entered at POR and after a charger exit. NORMAL is entered from STARTUP on the start-up-done strobe. FILTER is entered from STARTUP or NORMAL when the flag is sampled high. From FILTER the machine goes to BLACKOUT_RESET when the dip is confirmed, or back home (NORMAL if `sel_normal`, else STARTUP) when the flag drops. From BLACKOUT_RESET it goes to POWER_OFF on timeout, or back home after the release hold. From POWER_OFF it goes to STARTUP when the charger is present. The filter length, the timeout and the release hold are cycle-count parameters with defaults of 8, 64 and 16.

Top module: `blackout_seq`

## Requirements
- R1: After POR the block is in STARTUP: `sel_normal`=0 and `rst_out`, `pwroff_req` and `nvm_abort` are all 0.
- R2: A `startup_done` strobe sampled in STARTUP, with the flag low, sets `sel_normal` to 1 at that edge and enters NORMAL. `sel_normal` stays 1 until POR or a charger exit from POWER_OFF.
- R3: A dip is confirmed only when `cmp_low` is sampled high on FILT_CYC+1 consecutive edges. A run of FILT_CYC or fewer high samples leaves `rst_out` at 0.
- R4: `rst_out` goes to 1 right after the confirming edge, with no further delay.
- R5: `nvm_abort` is a one-cycle pulse, issued once per confirmed dip, in the first cycle that `rst_out` is 1.
- R6: In BLACKOUT_RESET, once `cmp_low` has been sampled low on HOLD_CYC consecutive edges, `rst_out` returns to 0 at the last of those edges and the block goes home.
- R7: With `sel_normal`=1, if the flag stays high, `pwroff_req` and `rst_out` are 1 exactly TOUT_CYC edges after the confirming edge.
- R8: A low sample of `cmp_low` during BLACKOUT_RESET restarts the timeout count, so high samples separated by a low one do not add up to a power-off.
- R9: With `sel_normal`=0, a confirmed dip of any length never raises `pwroff_req`.
- R10: POWER_OFF holds `pwroff_req` and `rst_out` at 1 and ignores `startup_done` until `charger_ok` is sampled high. That edge enters STARTUP with `sel_normal`=0 and both outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, asynchronous, active high |
| cmp_low | input | 1 | Comparator flag: supply below selected threshold |
| startup_done | input | 1 | One-cycle strobe marking the end of start-up |
| charger_ok | input | 1 | Charger present; releases power-off |
| sel_normal | output | 1 | Threshold select: 0 start-up level, 1 normal level |
| rst_out | output | 1 | Internal reset request |
| pwroff_req | output | 1 | Latched power-off request |
| nvm_abort | output | 1 | One-cycle abort strobe for non-volatile writes |

## Verification
Single dips of every length from 1 up to past the power-off point are run at both threshold levels. These sweeps separate an ignored dip from a confirmed one at the filter boundary, and a reset-only dip from an escalating one at the timeout boundary. They also show that the start-up level never escalates. For each dip the bench predicts arithmetically the first reset cycle, the abort cycle, the power-off cycle and the number of reset cycles. Two split patterns are also run. A filter run broken by one low sample must not confirm. A black-out broken by a short low gap must restart the timeout. A power-off recovery sequence checks that `startup_done` is ignored in POWER_OFF and that `charger_ok` releases it.

// File: rtl/bo_pkg.sv
package bo_pkg;
    typedef enum logic [2:0] {
        ST_STARTUP        = 3'd0,
        ST_NORMAL         = 3'd1,
        ST_FILTER         = 3'd2,
        ST_BLACKOUT_RESET = 3'd3,
        ST_POWER_OFF      = 3'd4
    } bo_state_e;
endpackage

// File: rtl/bo_level_latch.sv
// Threshold-select set/reset latch, clear dominant.
module bo_level_latch (
    input  logic clk,
    input  logic por,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk or posedge por) begin
        if (por)        q <= 1'b0;
        else if (clr_i) q <= 1'b0;
        else if (set_i) q <= 1'b1;
    end

    // R2
    latch_set_chk: assert property (@(posedge clk) disable iff (por)
        (set_i && !clr_i) |=> q);
endmodule

// File: rtl/bo_step_counter.sv
// Up counter with synchronous clear (clear wins over increment).
module bo_step_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             por,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or posedge por) begin
        if (por)      cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // R3 R7 R6: window counters never wrap
    no_wrap_chk: assert property (@(posedge clk) disable iff (por)
        (inc && !clr) |-> (cnt != '1));
endmodule

// File: rtl/blackout_seq.sv
module blackout_seq #(
    parameter int FILT_CYC = 8,
    parameter int TOUT_CYC = 64,
    parameter int HOLD_CYC = 16
) (
    input  logic clk,
    input  logic por,
    input  logic cmp_low,
    input  logic startup_done,
    input  logic charger_ok,
    output logic sel_normal,
    output logic rst_out,
    output logic pwroff_req,
    output logic nvm_abort
);
    import bo_pkg::*;

    localparam int FW = $clog2(FILT_CYC + 1);
    localparam int TW = $clog2(TOUT_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [FW-1:0] F_LAST = FW'(FILT_CYC - 1);
    localparam logic [TW-1:0] T_LAST = TW'(TOUT_CYC - 1);
    localparam logic [HW-1:0] H_LAST = HW'(HOLD_CYC - 1);

    bo_state_e state, nxt;
    logic [FW-1:0] fcnt;
    logic [TW-1:0] tcnt;
    logic [HW-1:0] hcnt;
    logic abort_q;
    bo_state_e home;

    assign home = sel_normal ? ST_NORMAL : ST_STARTUP;

    bo_level_latch u_level (
        .clk   (clk),
        .por   (por),
        .set_i (state == ST_STARTUP && startup_done),
        .clr_i (state == ST_POWER_OFF && charger_ok),
        .q     (sel_normal)
    );

    bo_step_counter #(.CNT_W(FW)) u_filt (
        .clk (clk), .por (por),
        .clr (state != ST_FILTER),
        .inc (state == ST_FILTER && cmp_low),
        .cnt (fcnt)
    );

    bo_step_counter #(.CNT_W(TW)) u_tout (
        .clk (clk), .por (por),
        .clr (state != ST_BLACKOUT_RESET || !cmp_low),
        .inc (state == ST_BLACKOUT_RESET && cmp_low && sel_normal),
        .cnt (tcnt)
    );

    bo_step_counter #(.CNT_W(HW)) u_hold (
        .clk (clk), .por (por),
        .clr (state != ST_BLACKOUT_RESET || cmp_low),
        .inc (state == ST_BLACKOUT_RESET && !cmp_low),
        .cnt (hcnt)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_STARTUP: begin
                if (cmp_low)           nxt = ST_FILTER;
                else if (startup_done) nxt = ST_NORMAL;
            end
            ST_NORMAL: begin
                if (cmp_low) nxt = ST_FILTER;
            end
            ST_FILTER: begin
                if (!cmp_low)            nxt = home;
                else if (fcnt == F_LAST) nxt = ST_BLACKOUT_RESET;
            end
            ST_BLACKOUT_RESET: begin
                if (cmp_low) begin
                    if (sel_normal && tcnt == T_LAST) nxt = ST_POWER_OFF;
                end else if (hcnt == H_LAST) begin
                    nxt = home;
                end
            end
            ST_POWER_OFF: begin
                if (charger_ok) nxt = ST_STARTUP;
            end
            default: nxt = ST_STARTUP;
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            state   <= ST_STARTUP;
            abort_q <= 1'b0;
        end else begin
            state   <= nxt;
            abort_q <= (state == ST_FILTER) && (nxt == ST_BLACKOUT_RESET);
        end
    end

    // outputs
    always_comb begin
        rst_out    = 1'b0;
        pwroff_req = 1'b0;
        unique case (state)
            ST_BLACKOUT_RESET: rst_out = 1'b1;
            ST_POWER_OFF: begin
                rst_out    = 1'b1;
                pwroff_req = 1'b1;
            end
            default: ;
        endcase
        nvm_abort = abort_q;
    end

    // R4
    rst_from_filter_chk: assert property (@(posedge clk) disable iff (por)
        $rose(rst_out) |-> ($past(state) == ST_FILTER));
    // R5
    abort_single_chk: assert property (@(posedge clk) disable iff (por)
        nvm_abort |=> !nvm_abort);
    // R5
    abort_with_rst_chk: assert property (@(posedge clk) disable iff (por)
        nvm_abort |-> (rst_out && $rose(rst_out)));
    // R9
    no_off_in_startup_chk: assert property (@(posedge clk) disable iff (por)
        $rose(pwroff_req) |-> $past(sel_normal));
    // R10
    off_latched_chk: assert property (@(posedge clk) disable iff (por)
        (pwroff_req && !charger_ok) |=> pwroff_req);
    // R10
    off_exit_chk: assert property (@(posedge clk) disable iff (por)
        (pwroff_req && charger_ok) |=> (!pwroff_req && !sel_normal && !rst_out));
endmodule

// File: tb/blackout_seq_test.sv
`timescale 1ns/1ps
module blackout_seq_test;
    localparam int FILT = 3;
    localparam int TOUT = 6;
    localparam int HOLD = 4;
    localparam int E    = FILT + 1;   // confirming edge index within a dip

    logic clk = 1'b0;
    logic por = 1'b1;
    logic cmp_low = 1'b0;
    logic startup_done = 1'b0;
    logic charger_ok = 1'b0;
    logic sel_normal, rst_out, pwroff_req, nvm_abort;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    blackout_seq #(.FILT_CYC(FILT), .TOUT_CYC(TOUT), .HOLD_CYC(HOLD)) uut (
        .clk(clk), .por(por), .cmp_low(cmp_low), .startup_done(startup_done),
        .charger_ok(charger_ok), .sel_normal(sel_normal), .rst_out(rst_out),
        .pwroff_req(pwroff_req), .nvm_abort(nvm_abort)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drives h1 high edges, lo low, h2 high, then tail low; sample i reflects edge i-1.
    task automatic run_dip(input int h1, input int lo, input int h2, input int tail,
                           output int n_rst, output int n_abort, output int f_rst,
                           output int f_abort, output int f_off, output int last_rst);
        int n;
        n = h1 + lo + h2 + tail;
        n_rst = 0; n_abort = 0; f_rst = 0; f_abort = 0; f_off = 0; last_rst = 0;
        for (int i = 1; i <= n + 1; i++) begin
            @(negedge clk);
            if (rst_out) begin n_rst++; if (f_rst == 0) f_rst = i; end
            if (nvm_abort) begin n_abort++; if (f_abort == 0) f_abort = i; end
            if (pwroff_req && f_off == 0) f_off = i;
            last_rst = int'(rst_out);
            cmp_low = (i <= h1) || (i > h1 + lo && i <= h1 + lo + h2);
        end
    endtask

    task automatic pulse_done();
        @(negedge clk) startup_done = 1'b1;
        @(negedge clk) startup_done = 1'b0;
    endtask

    task automatic pulse_charger();
        @(negedge clk) charger_ok = 1'b1;
        @(negedge clk) charger_ok = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int nr, na, fr, fa, fo, lr;
        repeat (3) @(negedge clk);
        por = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "sel_normal", sel_normal, 0);
        check("R1", "rst_out", rst_out, 0);
        check("R1", "pwroff_req", pwroff_req, 0);
        check("R1", "nvm_abort", nvm_abort, 0);

        // R9 start-up level sweep: never power-off
        for (int L = 1; L <= E + TOUT + 3; L++) begin
            run_dip(L, 0, 0, HOLD + 6, nr, na, fr, fa, fo, lr);
            check("R9", $sformatf("startup L=%0d pwroff first", L), fo, 0);
            check("R3", $sformatf("startup L=%0d rst cycles", L), nr, (L >= E) ? L + HOLD - E : 0);
            check("R6", $sformatf("startup L=%0d rst released", L), lr, 0);
            check("R2", $sformatf("startup L=%0d sel", L), sel_normal, 0);
        end

        // R2 start-up done
        pulse_done();
        check("R2", "sel after startup_done", sel_normal, 1);

        // R3 R4 R5 R6 R7 normal level sweep
        for (int L = 1; L <= E + TOUT + 2; L++) begin
            run_dip(L, 0, 0, HOLD + 6, nr, na, fr, fa, fo, lr);
            if (L < E) begin
                check("R3", $sformatf("L=%0d short dip rst", L), nr, 0);
                check("R5", $sformatf("L=%0d short dip abort", L), na, 0);
            end else begin
                check("R4", $sformatf("L=%0d first rst sample", L), fr, E + 1);
                check("R5", $sformatf("L=%0d abort count", L), na, 1);
                check("R5", $sformatf("L=%0d abort sample", L), fa, E + 1);
            end
            if (L - E >= TOUT) begin
                check("R7", $sformatf("L=%0d pwroff sample", L), fo, E + TOUT + 1);
                check("R10", $sformatf("L=%0d rst held in off", L), lr, 1);
                pulse_done();
                check("R10", "startup_done ignored pwroff", pwroff_req, 1);
                check("R10", "startup_done ignored sel", sel_normal, 1);
                pulse_charger();
                check("R10", "charger exit pwroff", pwroff_req, 0);
                check("R10", "charger exit sel", sel_normal, 0);
                check("R10", "charger exit rst", rst_out, 0);
                pulse_done();
                check("R2", "sel after recovery", sel_normal, 1);
            end else begin
                check("R7", $sformatf("L=%0d no pwroff", L), fo, 0);
                check("R6", $sformatf("L=%0d rst cycles", L), nr, (L >= E) ? L + HOLD - E : 0);
                check("R6", $sformatf("L=%0d rst released", L), lr, 0);
            end
        end

        // R3 filter run broken by a single low sample
        run_dip(FILT, 1, FILT, HOLD + 4, nr, na, fr, fa, fo, lr);
        check("R3", "broken filter run rst", nr, 0);

        // R8 timeout restarts after a short low gap
        run_dip(E + 3, 2, TOUT - 1, HOLD + 4, nr, na, fr, fa, fo, lr);
        check("R8", "split blackout pwroff", fo, 0);
        check("R8", "split blackout rst cycles", nr, (E + 3 + 2 + TOUT - 1) + HOLD - E);
        check("R5", "split blackout abort count", na, 1);
        check("R6", "split blackout released", lr, 0);

        finish_run();
    end
endmodule